// File: doc/BRIEF.md
# Tiered Reset Controller with Input Hold-Off

This block derives the internal resets of a time-measurement core from three sources: an asynchronous active-low power-up pin, two software strobes (a full reset and a partial reset), and an external trigger pin. The trigger pin can be routed to either software reset class by its own enable bit. Three reset outputs cover three scopes. The configuration reset clears only on power-up. The core reset clears on every reset class. The interface-FIFO reset clears on power-up and full resets but not on partial resets.

After any reset, a down-counter keeps `meas_en` low so that the start/stop measurement inputs are blocked for a fixed hold-off time. The power-up and full-reset hold-off is shorter than the partial-reset hold-off. Both are given in nanoseconds and rounded up to whole clock cycles. A new request that arrives during a hold-off restarts the counter with the hold-off of the new request.

Top module: `tier_rst_ctrl`

## Requirements
- R1: While `por_n` is low, `cfg_rst_n`, `core_rst_n`, `fifo_rst_n` and `meas_en` are all low, asynchronously to the clock.
- R2: After `por_n` rises, `cfg_rst_n` goes high on the second clock edge. `core_rst_n` and `fifo_rst_n` go high on the third edge. `meas_en` goes high HOLD_FULL edges after the second edge.
- R3: A full request sampled at an edge drives `core_rst_n` and `fifo_rst_n` low for exactly the following cycle. `cfg_rst_n` stays high.
- R4: A partial request sampled at an edge drives `core_rst_n` low for exactly the following cycle. `fifo_rst_n` and `cfg_rst_n` stay high.
- R5: `meas_en` is low whenever `core_rst_n` is low. It stays low for HOLD_FULL cycles after a full reset and for HOLD_PART cycles after a partial reset, counted from the cycle in which the reset is active. Each hold value is ceil(ns / CLK_NS), and at least 2.
- R6: When a full and a partial request are present in the same cycle, only the full reset is performed, with the full scope and the HOLD_FULL hold-off.
- R7: A request during a running hold-off restarts the count with the new request's hold-off. The new hold-off applies whether it is longer or shorter than the remaining one.
- R8: A trigger rising edge issues a full request when `trig_full_en` is 1 and a partial request when `trig_part_en` is 1. With both enable bits at 0, the trigger pin has no effect on any output.
- R9: `trig_pin` passes through a SYNC_STAGES-flop synchronizer and is rising-edge detected. A pulse held for several cycles gives exactly one reset. With 2 stages, the reset cycle begins on the third edge after the pin rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-up reset pin |
| sw_full_req | input | 1 | Software full-reset strobe, sampled each cycle |
| sw_part_req | input | 1 | Software partial-reset strobe, sampled each cycle |
| trig_pin | input | 1 | Asynchronous external reset trigger |
| trig_full_en | input | 1 | Routes trigger edges to the full reset |
| trig_part_en | input | 1 | Routes trigger edges to the partial reset |
| cfg_rst_n | output | 1 | Active-low reset of the configuration registers |
| core_rst_n | output | 1 | Active-low reset of the measurement core |
| fifo_rst_n | output | 1 | Active-low reset of the interface FIFOs |
| meas_en | output | 1 | High when start/stop inputs may be accepted |

## Verification
The bench builds the block with a 20 ns clock period and the default hold-off times of 40 ns and 75 ns. With these values the full hold-off is exactly 2 cycles. The partial hold-off is 3.75 cycles, rounded up to 4, so both the exact case and the round-up case of the conversion are covered. The short full hold-off is also the smallest legal value, so the bench sees `meas_en` rise on the first cycle that the checker permits. The gap between 2 and 4 cycles lets the restart tests tell a lengthened hold-off from a shortened one.

// File: rtl/tier_rst_pkg.sv
package tier_rst_pkg;

   typedef enum logic [1:0] {
      TIER_NONE = 2'd0,
      TIER_PART = 2'd1,
      TIER_FULL = 2'd2
   } tier_e;

   // round a time up to whole clock periods
   function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                input int unsigned clk_ns);
      return (t_ns + clk_ns - 1) / clk_ns;
   endfunction

endpackage

// File: rtl/tier_rst_sync.sv
module tier_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tier_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tier_rst_edge.sv
module tier_rst_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/tier_rst_arb.sv
module tier_rst_arb
   import tier_rst_pkg::*;
(
   input  logic  sw_full,
   input  logic  sw_part,
   input  logic  trig_rise,
   input  logic  en_full,
   input  logic  en_part,
   output logic  full_any,
   output logic  part_any,
   output tier_e tier
);
   always_comb begin
      full_any = sw_full | (trig_rise & en_full);
      part_any = sw_part | (trig_rise & en_part);
      // the wider scope wins
      if (full_any)      tier = TIER_FULL;
      else if (part_any) tier = TIER_PART;
      else               tier = TIER_NONE;
   end
endmodule

// File: rtl/tier_rst_holdoff.sv
module tier_rst_holdoff
   import tier_rst_pkg::*;
#(
   parameter int unsigned HOLD_FULL = 4,
   parameter int unsigned HOLD_PART = 8
) (
   input  logic  clk,
   input  logic  por_n,
   input  logic  por_ok,
   input  tier_e tier,
   output logic  core_rst_n,
   output logic  fifo_rst_n,
   output logic  meas_en
);
   localparam int unsigned HOLD_MAX = (HOLD_FULL > HOLD_PART) ? HOLD_FULL : HOLD_PART;
   localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);
   localparam logic [CNT_W-1:0] LOAD_FULL = CNT_W'(HOLD_FULL);
   localparam logic [CNT_W-1:0] LOAD_PART = CNT_W'(HOLD_PART);

   if (HOLD_FULL < 2 || HOLD_PART < 2) begin : g_bad_hold
      $error("tier_rst_holdoff: hold-off must cover at least 2 cycles");
   end

   logic [CNT_W-1:0] cnt;
   logic             core_act;
   logic             fifo_act;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt      <= LOAD_FULL;
         core_act <= 1'b1;
         fifo_act <= 1'b1;
      end else if (!por_ok) begin
         cnt      <= LOAD_FULL;
         core_act <= 1'b1;
         fifo_act <= 1'b1;
      end else begin
         unique case (tier)
            TIER_FULL: begin
               cnt      <= LOAD_FULL;
               core_act <= 1'b1;
               fifo_act <= 1'b1;
            end
            TIER_PART: begin
               cnt      <= LOAD_PART;
               core_act <= 1'b1;
               fifo_act <= 1'b0;
            end
            default: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               core_act <= 1'b0;
               fifo_act <= 1'b0;
            end
         endcase
      end
   end

   assign core_rst_n = ~core_act;
   assign fifo_rst_n = ~fifo_act;
   assign meas_en    = (cnt == '0);
endmodule

// File: rtl/tier_rst_ctrl.sv
module tier_rst_ctrl
   import tier_rst_pkg::*;
#(
   parameter int unsigned CLK_NS      = 10,
   parameter int unsigned FULL_NS     = 40,
   parameter int unsigned PART_NS     = 75,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic sw_full_req,
   input  logic sw_part_req,
   input  logic trig_pin,
   input  logic trig_full_en,
   input  logic trig_part_en,
   output logic cfg_rst_n,
   output logic core_rst_n,
   output logic fifo_rst_n,
   output logic meas_en
);
   localparam int unsigned HOLD_FULL = ns_to_cycles(FULL_NS, CLK_NS);
   localparam int unsigned HOLD_PART = ns_to_cycles(PART_NS, CLK_NS);

   if (CLK_NS == 0) begin : g_bad_clk
      $error("tier_rst_ctrl: CLK_NS must be nonzero");
   end

   logic  por_ok;
   logic  trig_sync;
   logic  trig_rise;
   logic  full_any;
   logic  part_any;
   tier_e tier;

   tier_rst_sync #(.STAGES(2)) u_por_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (1'b1),
      .q     (por_ok)
   );

   tier_rst_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (trig_pin),
      .q     (trig_sync)
   );

   tier_rst_edge u_trig_edge (
      .clk   (clk),
      .rst_n (por_n),
      .lvl   (trig_sync),
      .rise  (trig_rise)
   );

   tier_rst_arb u_arb (
      .sw_full   (sw_full_req),
      .sw_part   (sw_part_req),
      .trig_rise (trig_rise),
      .en_full   (trig_full_en),
      .en_part   (trig_part_en),
      .full_any  (full_any),
      .part_any  (part_any),
      .tier      (tier)
   );

   tier_rst_holdoff #(
      .HOLD_FULL (HOLD_FULL),
      .HOLD_PART (HOLD_PART)
   ) u_hold (
      .clk        (clk),
      .por_n      (por_n),
      .por_ok     (por_ok),
      .tier       (tier),
      .core_rst_n (core_rst_n),
      .fifo_rst_n (fifo_rst_n),
      .meas_en    (meas_en)
   );

   assign cfg_rst_n = por_ok;
endmodule

// File: rtl/tier_rst_chk.sv
module tier_rst_chk #(
   parameter int unsigned HOLD_FULL = 4,
   parameter int unsigned HOLD_PART = 8
) (
   input logic clk,
   input logic por_n,
   input logic full_any,
   input logic part_any,
   input logic trig_rise,
   input logic cfg_rst_n,
   input logic core_rst_n,
   input logic fifo_rst_n,
   input logic meas_en
);
   // cycles of hold-off still expected, rebuilt from the reset outputs
   int unsigned left;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)            left <= HOLD_FULL - 1;
      else if (!core_rst_n)  left <= (fifo_rst_n ? HOLD_PART : HOLD_FULL) - 1;
      else if (left != 0)    left <= left - 1;
   end

   always @(negedge clk) begin
      if (!por_n) begin
         a_r1_por_all_low: assert (!cfg_rst_n && !core_rst_n && !fifo_rst_n && !meas_en)
            else $error("R1: outputs not all low during power-up reset");
      end
   end

   a_r3_full_scope: assert property (@(posedge clk) disable iff (!por_n)
      full_any |=> (!core_rst_n && !fifo_rst_n));

   a_r4_part_keeps_fifo: assert property (@(posedge clk) disable iff (!por_n)
      (cfg_rst_n && part_any && !full_any) |=> (!core_rst_n && fifo_rst_n));

   a_r5_blocked_in_reset: assert property (@(posedge clk) disable iff (!por_n)
      !core_rst_n |-> !meas_en);

   a_r5_holdoff_len: assert property (@(posedge clk) disable iff (!por_n)
      core_rst_n |-> (meas_en == (left == 0)));

   a_r9_single_edge: assert property (@(posedge clk) disable iff (!por_n)
      trig_rise |=> !trig_rise);
endmodule

bind tier_rst_ctrl tier_rst_chk #(
   .HOLD_FULL (HOLD_FULL),
   .HOLD_PART (HOLD_PART)
) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .full_any   (full_any),
   .part_any   (part_any),
   .trig_rise  (trig_rise),
   .cfg_rst_n  (cfg_rst_n),
   .core_rst_n (core_rst_n),
   .fifo_rst_n (fifo_rst_n),
   .meas_en    (meas_en)
);

// File: tb/tb_tier_rst_ctrl.sv
module tb_tier_rst_ctrl;
   // 20 ns clock: 40 ns -> 2 cycles, 75 ns -> 4 cycles (rounded up)
   localparam int EXP_FULL = 2;
   localparam int EXP_PART = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sw_full_req = 1'b0;
   logic sw_part_req = 1'b0;
   logic trig_pin = 1'b0;
   logic trig_full_en = 1'b0;
   logic trig_part_en = 1'b0;
   logic cfg_rst_n, core_rst_n, fifo_rst_n, meas_en;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   tier_rst_ctrl #(.CLK_NS(20), .FULL_NS(40), .PART_NS(75), .SYNC_STAGES(2)) dut (
      .clk          (clk),
      .por_n        (por_n),
      .sw_full_req  (sw_full_req),
      .sw_part_req  (sw_part_req),
      .trig_pin     (trig_pin),
      .trig_full_en (trig_full_en),
      .trig_part_en (trig_part_en),
      .cfg_rst_n    (cfg_rst_n),
      .core_rst_n   (core_rst_n),
      .fifo_rst_n   (fifo_rst_n),
      .meas_en      (meas_en)
   );

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", what, act, exp);
      end
   endtask

   // count samples with meas_en low, starting at the current negedge
   task automatic count_block(output int n);
      n = 0;
      while (!meas_en && n < 50) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_power_up;
      int n;
      @(negedge clk);
      chk({cfg_rst_n, core_rst_n, fifo_rst_n, meas_en}, 0, "R1 outputs during por");
      #3 por_n = 1'b0;
      #1 chk({cfg_rst_n, core_rst_n, fifo_rst_n, meas_en}, 0, "R1 async por assert");
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      chk(cfg_rst_n, 0, "R2 cfg after first edge");
      @(negedge clk);
      chk(cfg_rst_n, 1, "R2 cfg after second edge");
      chk(core_rst_n, 0, "R2 core after second edge");
      count_block(n);
      chk(n, EXP_FULL, "R2 power-up hold-off");
      chk({core_rst_n, fifo_rst_n}, 2'b11, "R2 core/fifo released");
   endtask

   task automatic t_request(input bit full, input bit part, input int exp_hold,
                            input bit exp_fifo_low, input string tag);
      int n;
      chk(meas_en, 1, {tag, " idle before request"});
      sw_full_req = full;
      sw_part_req = part;
      @(negedge clk);
      sw_full_req = 1'b0;
      sw_part_req = 1'b0;
      chk(core_rst_n, 0, {tag, " core reset"});
      chk(fifo_rst_n, !exp_fifo_low, {tag, " fifo reset"});
      chk(cfg_rst_n, 1, {tag, " cfg untouched"});
      chk(meas_en, 0, {tag, " R5 blocked in reset"});
      count_block(n);
      chk(n, exp_hold, {tag, " hold-off length"});
      @(negedge clk);
      chk(core_rst_n & fifo_rst_n, 1, {tag, " single-cycle reset"});
   endtask

   task automatic t_restart(input bit first_full, input int exp_hold, input string tag);
      int n;
      sw_full_req = first_full;
      sw_part_req = !first_full;
      @(negedge clk);
      sw_full_req = !first_full;
      sw_part_req = first_full;
      @(negedge clk);
      sw_full_req = 1'b0;
      sw_part_req = 1'b0;
      chk(fifo_rst_n, first_full, {tag, " second request scope"});
      count_block(n);
      chk(n, exp_hold, {tag, " restarted hold-off"});
      repeat (2) @(negedge clk);
   endtask

   task automatic t_trigger(input bit en_f, input bit en_p, input int exp_core,
                            input int exp_fifo, input string tag);
      int nc = 0;
      int nf = 0;
      int nm = 0;
      int first = -1;
      trig_full_en = en_f;
      trig_part_en = en_p;
      @(negedge clk);
      trig_pin = 1'b1;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (i == 4) trig_pin = 1'b0;
         if (!core_rst_n) begin
            nc++;
            if (first < 0) first = i;
         end
         if (!fifo_rst_n) nf++;
         if (!meas_en) nm++;
      end
      chk(nc, exp_core, {tag, " core reset count"});
      chk(nf, exp_fifo, {tag, " fifo reset count"});
      if (exp_core == 0) chk(nm, 0, {tag, " R8 meas_en untouched"});
      else chk(first, 3, {tag, " R9 sync latency"});
      trig_full_en = 1'b0;
      trig_part_en = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_power_up();
      repeat (2) @(negedge clk);
      t_request(1, 0, EXP_FULL, 1, "R3 full");
      t_request(0, 1, EXP_PART, 0, "R4 partial");
      t_request(1, 1, EXP_FULL, 1, "R6 both");
      t_restart(1, EXP_PART, "R7 lengthen");
      t_restart(0, EXP_FULL, "R7 shorten");
      t_trigger(1, 0, 1, 1, "R8 trig full");
      t_trigger(0, 1, 1, 0, "R8 trig part");
      t_trigger(0, 0, 0, 0, "R8 trig off");
      t_trigger(1, 1, 1, 1, "R9 trig both");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cycles, 5000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule